// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block puts the byte-wide registers of a two-wire serial controller behind a single 64-bit command word that the host writes and reads back. One write carries a start flag, an operation code with a register selector, a direction flag and a data byte. The bridge keeps the word busy for a fixed number of cycles and performs the internal access. For a read, it puts the register value in the low byte. It then drops the start flag. The host polls the word until that flag is clear.

The controller registers live in the bridge: a data byte, a control byte, a clock-control byte, a clock high-period byte and a status byte. Their values drive the serial engine outputs. The engine can load the status byte through a strobe. A soft-reset command puts the controller back into its idle state.

Top module: `ira_bridge`

## Requirements
- R1: After reset the command word reads zero, status reads 0xF8, and data, control and clock-control read 0x00. The clock high-period register reads THP_RESET (default 0x18).
- R2: A host write whose bit 63 is set, made while bit 63 of the word is clear, loads the word. Bit 63 then reads 1 for exactly LATENCY clock edges, counting from the loading edge, and clears on the edge that completes the access.
- R3: While bit 63 of the word is set, host writes are ignored: neither the word nor any register changes.
- R4: When bit 56 is clear, the access writes the byte in bits 7:0. With bits 59:58 = 2'b11, selector bits 34:32 pick the target: 1 is data, 2 is control, 3 is clock-control. With bits 59:58 = 2'b10 and selector 0, the target is the clock high-period register.
- R5: When bit 56 is set, the access reads. On completion, bits 7:0 of the word hold the selected register and bits 62:8 keep the value written. Under bits 59:58 = 2'b11, selector 3 reads status, not clock-control.
- R6: A write with bits 59:58 = 2'b11 and selector 7 sets status to 0xF8 and control to 0x00. Data, clock-control and clock high-period keep their values.
- R7: Any other operation or selector still completes after LATENCY edges. This covers selectors 0, 4, 5 and 6, bits 59:58 of 2'b00 or 2'b01, a non-zero selector under 2'b10, and a read of selector 7. A read returns 0x00 in bits 7:0, and a write changes no register.
- R8: A host write with bit 63 clear is ignored; the word and all registers keep their values.
- R9: The engine status strobe loads status on the next edge. If a soft reset completes on the same edge, the soft reset wins and status becomes 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wr_data | input | 64 | Command word written by the host |
| host_rd_data | output | 64 | Current command word (bit 63 = busy) |
| eng_stat_we | input | 1 | Engine status load strobe |
| eng_stat_in | input | 8 | Status value from the serial engine |
| data_o | output | 8 | Data register |
| ctl_o | output | 8 | Control register |
| clkctl_o | output | 8 | Clock-control register |
| thp_o | output | 8 | Clock high-period register |
| stat_o | output | 8 | Status register |

## Verification
The bench builds the bridge with LATENCY = 3 and the default THP_RESET of 0x18. Three edges of latency give a busy window of several cycles. Inside that window the bench can issue a second write, and it can hold an engine status strobe across the whole access so that it meets a completing soft reset on the same edge. The default reset value of the clock high-period register makes its value after reset a known constant that the bench can check.

// File: rtl/ira_pkg.sv
package ira_pkg;
    localparam int WORD_W   = 64;
    localparam int BYTE_W   = 8;
    localparam int VALID_B  = 63;
    localparam int READ_B   = 56;
    localparam int OP_HI    = 59;
    localparam int OP_LO    = 58;
    localparam int SEL_HI   = 34;
    localparam int SEL_LO   = 32;
    localparam int SEL_W    = SEL_HI - SEL_LO + 1;
    localparam logic [BYTE_W-1:0] IDLE_STATUS = 8'hF8;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DATA,
        TGT_CTL,
        TGT_CLKCTL,
        TGT_STATUS,
        TGT_THP,
        TGT_SRST
    } tgt_e;
endpackage

// File: rtl/ira_decode.sv
module ira_decode
    import ira_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output tgt_e              tgt_o,
    output logic              is_read_o
);
    logic [1:0]       op;
    logic [SEL_W-1:0] sel;

    always_comb begin
        op        = word_i[OP_HI:OP_LO];
        sel       = word_i[SEL_HI:SEL_LO];
        is_read_o = word_i[READ_B];
        tgt_o     = TGT_NONE;
        if (op == 2'b11) begin
            case (sel)
                3'd1:    tgt_o = TGT_DATA;
                3'd2:    tgt_o = TGT_CTL;
                3'd3:    tgt_o = is_read_o ? TGT_STATUS : TGT_CLKCTL;
                3'd7:    tgt_o = is_read_o ? TGT_NONE : TGT_SRST;
                default: tgt_o = TGT_NONE;
            endcase
        end else if (op == 2'b10 && sel == '0) begin
            tgt_o = TGT_THP;
        end
    end
endmodule

// File: rtl/ira_regbank.sv
module ira_regbank
    import ira_pkg::*;
#(
    parameter logic [BYTE_W-1:0] THP_RESET = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  tgt_e              tgt,
    input  logic              is_read,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              eng_stat_we,
    input  logic [BYTE_W-1:0] eng_stat_in,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] data_o,
    output logic [BYTE_W-1:0] ctl_o,
    output logic [BYTE_W-1:0] clkctl_o,
    output logic [BYTE_W-1:0] thp_o,
    output logic [BYTE_W-1:0] stat_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] ctl;
        logic [BYTE_W-1:0] clkctl;
        logic [BYTE_W-1:0] thp;
        logic [BYTE_W-1:0] stat;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  do_wr;

    always_comb begin
        regs_d = regs_q;
        do_wr  = acc_en && !is_read;
        if (eng_stat_we) regs_d.stat = eng_stat_in;
        if (do_wr) begin
            case (tgt)
                TGT_DATA:   regs_d.data   = wdata;
                TGT_CTL:    regs_d.ctl    = wdata;
                TGT_CLKCTL: regs_d.clkctl = wdata;
                TGT_THP:    regs_d.thp    = wdata;
                TGT_SRST: begin
                    regs_d.stat = IDLE_STATUS;
                    regs_d.ctl  = '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (tgt)
            TGT_DATA:   rdata = regs_q.data;
            TGT_CTL:    rdata = regs_q.ctl;
            TGT_STATUS: rdata = regs_q.stat;
            TGT_THP:    rdata = regs_q.thp;
            default:    rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{data: '0, ctl: '0, clkctl: '0, thp: THP_RESET, stat: IDLE_STATUS};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign data_o   = regs_q.data;
    assign ctl_o    = regs_q.ctl;
    assign clkctl_o = regs_q.clkctl;
    assign thp_o    = regs_q.thp;
    assign stat_o   = regs_q.stat;

    // R6
    srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !is_read && tgt == TGT_SRST) |=> (stat_o == IDLE_STATUS && ctl_o == '0));

    // R7
    none_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && tgt == TGT_NONE) |=>
        ($stable(data_o) && $stable(ctl_o) && $stable(clkctl_o) && $stable(thp_o)));

    // R7
    none_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_NONE) |-> (rdata == '0));
endmodule

// File: rtl/ira_bridge.sv
module ira_bridge
    import ira_pkg::*;
#(
    parameter int                LATENCY   = 2,
    parameter logic [BYTE_W-1:0] THP_RESET = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_data,
    output logic [WORD_W-1:0] host_rd_data,
    input  logic              eng_stat_we,
    input  logic [BYTE_W-1:0] eng_stat_in,
    output logic [BYTE_W-1:0] data_o,
    output logic [BYTE_W-1:0] ctl_o,
    output logic [BYTE_W-1:0] clkctl_o,
    output logic [BYTE_W-1:0] thp_o,
    output logic [BYTE_W-1:0] stat_o
);
    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t            st_d, st_q;
    tgt_e              tgt;
    logic              is_read;
    logic              busy;
    logic              acc_en;
    logic [BYTE_W-1:0] rdata;

    ira_decode u_decode (
        .word_i    (st_q.word),
        .tgt_o     (tgt),
        .is_read_o (is_read)
    );

    ira_regbank #(.THP_RESET(THP_RESET)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (acc_en),
        .tgt         (tgt),
        .is_read     (is_read),
        .wdata       (st_q.word[BYTE_W-1:0]),
        .eng_stat_we (eng_stat_we),
        .eng_stat_in (eng_stat_in),
        .rdata       (rdata),
        .data_o      (data_o),
        .ctl_o       (ctl_o),
        .clkctl_o    (clkctl_o),
        .thp_o       (thp_o),
        .stat_o      (stat_o)
    );

    always_comb begin
        st_d   = st_q;
        busy   = st_q.word[VALID_B];
        acc_en = busy && (st_q.cnt == CNT_LAST);
        if (busy) begin
            if (acc_en) begin
                st_d.word[VALID_B] = 1'b0;
                st_d.cnt           = '0;
                if (is_read) st_d.word[BYTE_W-1:0] = rdata;
            end else begin
                st_d.cnt = st_q.cnt - CNT_LAST;
            end
        end else if (host_wr_en && host_wr_data[VALID_B]) begin
            st_d.word = host_wr_data;
            st_d.cnt  = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rd_data = st_q.word;

    // R2
    start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rd_data[VALID_B]) |-> $past(host_wr_en && host_wr_data[VALID_B]));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_data[VALID_B] |-> (st_q.cnt >= CNT_LAST && st_q.cnt <= CNT_LOAD));

    // R3
    busy_ignores_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_data[VALID_B] && host_wr_en) |=>
        (host_rd_data[WORD_W-2:BYTE_W] == $past(host_rd_data[WORD_W-2:BYTE_W])));

    // R8
    idle_clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd_data[VALID_B] && host_wr_en && !host_wr_data[VALID_B]) |=> $stable(host_rd_data));
endmodule

// File: tb/tb_ira_bridge.sv
module tb_ira_bridge;
    localparam int LAT = 3;
    localparam int NV  = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [63:0] host_wr_data = '0;
    logic [63:0] host_rd_data;
    logic        eng_stat_we = 1'b0;
    logic [7:0]  eng_stat_in = '0;
    logic [7:0]  data_o, ctl_o, clkctl_o, thp_o, stat_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ira_bridge #(.LATENCY(LAT)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
        .eng_stat_we(eng_stat_we), .eng_stat_in(eng_stat_in),
        .data_o(data_o), .ctl_o(ctl_o), .clkctl_o(clkctl_o), .thp_o(thp_o), .stat_o(stat_o)
    );

    always #5 clk = ~clk;

    // command (valid bit added by the bench) and expected low byte on completion
    localparam logic [71:0] VEC [NV] = '{
        {64'h0C00_0001_0000_00A5, 8'hA5},  // R4 write data
        {64'h0C00_0002_0000_0044, 8'h44},  // R4 write control
        {64'h0C00_0003_0000_0013, 8'h13},  // R4 write clock-control
        {64'h0800_0000_0000_002A, 8'h2A},  // R4 write clock high-period
        {64'h0C00_0004_0000_0099, 8'h99},  // R7 unlisted selector write
        {64'h0400_0001_0000_0055, 8'h55},  // R7 unlisted op write
        {64'h0800_0002_0000_00EE, 8'hEE},  // R7 high-period op, selector non-zero
        {64'h0D00_0001_0000_0000, 8'hA5},  // R5 read data
        {64'h0D00_0002_0000_0000, 8'h44},  // R5 read control
        {64'h0D00_0003_0000_0000, 8'hF8},  // R5 selector 3 read gives status
        {64'h0900_0000_0000_0000, 8'h2A},  // R5 read clock high-period
        {64'h0D00_0005_0000_0077, 8'h00},  // R7 unlisted selector read
        {64'h0D00_0007_0000_0066, 8'h00},  // R7 read of reset selector
        {64'h0D00_0000_0000_0011, 8'h00}   // R7 selector 0 read
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [63:0] c, output logic [63:0] res);
        logic ok;
        ok = 1'b1;
        @(negedge clk);
        host_wr_en   = 1'b1;
        host_wr_data = c | 64'h8000_0000_0000_0000;
        @(negedge clk);
        host_wr_en = 1'b0;
        if (host_rd_data[63] !== 1'b1) ok = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            @(negedge clk);
            if (host_rd_data[63] !== 1'b1) ok = 1'b0;
        end
        @(negedge clk);
        if (host_rd_data[63] !== 1'b0) ok = 1'b0;
        check("R2 busy window", {63'd0, ok}, 64'd1);
        res = host_rd_data;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL R2 watchdog actual=hung expected=done");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] res;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 word", host_rd_data, 64'd0);
        check("R1 status", {56'd0, stat_o}, 64'hF8);
        check("R1 data/ctl/clkctl", {40'd0, data_o, ctl_o, clkctl_o}, 64'd0);
        check("R1 thp", {56'd0, thp_o}, 64'h18);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_cmd(VEC[i][71:8], res);
            check("R4/R5/R7 word", res, {1'b0, VEC[i][70:16], VEC[i][7:0]});
        end
        // R4 outputs, R7 writes left them untouched
        check("R4 data_o", {56'd0, data_o}, 64'hA5);
        check("R4 ctl_o", {56'd0, ctl_o}, 64'h44);
        check("R4 clkctl_o", {56'd0, clkctl_o}, 64'h13);
        check("R7 thp_o kept", {56'd0, thp_o}, 64'h2A);

        // R3 write during busy ignored
        @(negedge clk);
        host_wr_en = 1'b1;
        host_wr_data = 64'h8C00_0001_0000_0011;
        @(negedge clk);
        host_wr_data = 64'h8C00_0002_0000_0022;
        @(negedge clk);
        host_wr_en = 1'b0;
        repeat (LAT) @(negedge clk);
        check("R3 word", host_rd_data, 64'h0C00_0001_0000_0011);
        check("R3 ctl unchanged", {56'd0, ctl_o}, 64'h44);
        check("R3 data written once", {56'd0, data_o}, 64'h11);

        // R8 write with valid clear ignored
        @(negedge clk);
        host_wr_en = 1'b1;
        host_wr_data = 64'h0C00_0002_0000_0033;
        @(negedge clk);
        host_wr_en = 1'b0;
        repeat (LAT) @(negedge clk);
        check("R8 word", host_rd_data, 64'h0C00_0001_0000_0011);
        check("R8 ctl", {56'd0, ctl_o}, 64'h44);

        // R9 engine status load
        @(negedge clk);
        eng_stat_we = 1'b1;
        eng_stat_in = 8'h08;
        @(negedge clk);
        eng_stat_we = 1'b0;
        check("R9 status load", {56'd0, stat_o}, 64'h08);
        run_cmd(64'h0D00_0003_0000_0000, res);
        check("R9 status read", {56'd0, res[7:0]}, 64'h08);

        // R6 soft reset
        run_cmd(64'h0C00_0007_0000_0000, res);
        check("R6 status idle", {56'd0, stat_o}, 64'hF8);
        check("R6 ctl cleared", {56'd0, ctl_o}, 64'h00);
        check("R6 others kept", {40'd0, data_o, clkctl_o, thp_o}, {40'd0, 8'h11, 8'h13, 8'h2A});

        // R9 soft reset wins over a simultaneous engine load
        @(negedge clk);
        eng_stat_we = 1'b1;
        eng_stat_in = 8'h50;
        host_wr_en = 1'b1;
        host_wr_data = 64'h8C00_0007_0000_0000;
        @(negedge clk);
        host_wr_en = 1'b0;
        check("R9 engine load while busy", {56'd0, stat_o}, 64'h50);
        repeat (LAT) @(negedge clk);
        eng_stat_we = 1'b0;
        check("R9 soft reset priority", {56'd0, stat_o}, 64'hF8);
        check("R9 access done", {63'd0, host_rd_data[63]}, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule